// File: doc/BRIEF.md
# Energy-Detect Transmit Blocking Monitor

This block watches how busy a radio channel is and holds off transmission while the channel stays occupied. It counts the clock cycles in which an energy-detect input is asserted. At the end of each fixed-length evaluation period it turns that count into a busy percentage of the period. The period counts as busy when the percentage is above a limit.

A hysteresis rule sits on top of that decision. Two run counters track consecutive busy and consecutive quiet periods, and each one clears the other. Transmission is blocked once the busy run reaches three periods. It is released once the quiet run reaches three periods.

While the gate is closed, the MAC transmit enable, the automatic-response enable and the two antenna-path enables are driven low. The RF and T/R-switch pin enables are driven high again whenever the gate opens. A band select picks the energy threshold, which is driven out duplicated in both bytes of a 16-bit word. The whole mechanism runs only while a regulatory-mode input is high. Dropping that input, or pulsing the re-initialisation input, clears the history and opens the gate.

Top module: `edg_txgate`

## Requirements
- R1: At every period end, `busy_pct_o` shows floor(busy_cycles × 100 / PERIOD), clamped to at most 100. `eval_vld_o` is high for exactly one cycle per period while it is valid. The period holds PERIOD cycles and counts the energy input of every cycle in it.
- R2: A period counts as busy only when its busy percentage is strictly greater than 90. A percentage of exactly 90 counts as quiet.
- R3: `tx_blocked_o` goes high in the cycle after the third consecutive busy evaluation. Any quiet evaluation restarts the busy run.
- R4: A blocked gate reopens in the cycle after the third consecutive quiet evaluation. Any busy evaluation restarts the quiet run.
- R5: `tx_blocked_o` changes only in the cycle after an `eval_vld_o` pulse, or after `reinit_i` is high or `regmode_i` is low.
- R6: While blocked, `mac_tx_en_o`, `auto_rsp_en_o`, `tx_ant_en_o` and `rx_ant_en_o` are 0, and while unblocked they are 1. `rf_pin_en_o` and `trsw_en_o` stay 1 in both states.
- R7: A `reinit_i` pulse clears both run counters and unblocks in the next cycle. A new period starts with the first cycle after the pulse.
- R8: While `regmode_i` is 0, no evaluation takes place (`eval_vld_o` stays 0) and the gate stays open. Lowering `regmode_i` while blocked unblocks in the next cycle.
- R9: `ed_thresh_o` equals {th, th} with th = 8'h0E when `band_hi_i` is 1 and th = 8'h20 otherwise. It is registered, so it is valid one cycle after `band_hi_i` changes.
- R10: After reset the gate is open, every enable output is 1, `eval_vld_o` is 0 and `ed_thresh_o` is 16'h2020.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| energy_i | input | 1 | Energy above threshold in this cycle |
| regmode_i | input | 1 | Regulatory monitoring enable |
| reinit_i | input | 1 | Re-initialisation pulse (channel or region change) |
| band_hi_i | input | 1 | High band selected |
| eval_vld_o | output | 1 | Period evaluation strobe |
| busy_pct_o | output | 7 | Busy percentage of the finished period |
| tx_blocked_o | output | 1 | Transmission currently blocked |
| mac_tx_en_o | output | 1 | MAC transmit enable |
| auto_rsp_en_o | output | 1 | Automatic response enable |
| tx_ant_en_o | output | 1 | Transmit antenna path enable |
| rx_ant_en_o | output | 1 | Receive antenna path enable |
| rf_pin_en_o | output | 1 | RF pin enable |
| trsw_en_o | output | 1 | T/R switch pin enable |
| ed_thresh_o | output | 16 | Duplicated energy threshold |

## Verification
The bench uses a period length of 75 so that the floor in the percentage matters.
- 68 busy cycles gives 90 %, which must count as quiet. A design that compares with "greater or equal", or rounds up, would start blocking there.
- A full period must give exactly 100.
- Busy and quiet runs broken after two periods must not toggle the gate. A design whose counters do not clear each other would block or unblock early.
- Re-initialisation and a drop of the regulatory mode are applied while blocked. A design that keeps the old run count would block again after only one or two busy periods.

// File: rtl/edg_pkg.sv
package edg_pkg;

    // Transmit-path enables driven by the gate
    typedef struct packed {
        logic mac_tx;
        logic auto_rsp;
        logic tx_ant;
        logic rx_ant;
        logic rf_pin;
        logic trsw;
    } tx_enables_t;

    localparam tx_enables_t EN_ALL_ON = '{
        mac_tx: 1'b1, auto_rsp: 1'b1, tx_ant: 1'b1,
        rx_ant: 1'b1, rf_pin: 1'b1, trsw: 1'b1
    };

    localparam int unsigned PCT_W = 7;

endpackage

// File: rtl/edg_acc.sv
// Period timer plus busy-cycle accumulator; emits the total at each period end.
module edg_acc #(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             energy_i,
    output logic             eval_vld_o,
    output logic [CNT_W-1:0] busy_tot_o
);

    localparam logic [CNT_W-1:0] LAST_CYC = CNT_W'(PERIOD - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cyc;
        logic [CNT_W-1:0] busy;
        logic [CNT_W-1:0] total;
        logic             vld;
    } acc_state_t;

    acc_state_t st_d, st_q;
    logic [CNT_W-1:0] busy_inc;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        // saturating add of this cycle's energy flag
        if (energy_i && (st_q.busy != CNT_MAX)) begin
            busy_inc = st_q.busy + 1'b1;
        end else begin
            busy_inc = st_q.busy;
        end
        if (clr_i) begin
            st_d.cyc  = '0;
            st_d.busy = '0;
        end else if (st_q.cyc == LAST_CYC) begin
            st_d.vld   = 1'b1;
            st_d.total = busy_inc;
            st_d.cyc   = '0;
            st_d.busy  = '0;
        end else begin
            st_d.cyc  = (st_q.cyc == CNT_MAX) ? st_q.cyc : st_q.cyc + 1'b1;
            st_d.busy = busy_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eval_vld_o = st_q.vld;
    assign busy_tot_o = st_q.total;

endmodule

// File: rtl/edg_pct.sv
// Busy total -> percentage of the period, clamped at 100.
module edg_pct #(
    parameter int unsigned PERIOD = 1000,
    parameter int unsigned CNT_W  = $clog2(PERIOD + 1)
) (
    input  logic [CNT_W-1:0]            busy_tot_i,
    output logic [edg_pkg::PCT_W-1:0]   pct_o
);

    localparam int unsigned PROD_W = CNT_W + 7;
    localparam logic [PROD_W-1:0] HUNDRED = PROD_W'(100);
    localparam logic [PROD_W-1:0] DIVISOR = PROD_W'(PERIOD);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] quot;

    always_comb begin
        prod = PROD_W'(busy_tot_i) * HUNDRED;
        quot = prod / DIVISOR;
        if (quot > HUNDRED) begin
            pct_o = edg_pkg::PCT_W'(100);
        end else begin
            pct_o = edg_pkg::PCT_W'(quot);
        end
    end

endmodule

// File: rtl/edg_hyst.sv
// Consecutive busy/quiet run counters and the transmit gate.
module edg_hyst
    import edg_pkg::*;
#(
    parameter int unsigned RUN_W      = 8,
    parameter int unsigned BLOCK_RUNS = 2,
    parameter int unsigned BUSY_PCT   = 90
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             eval_vld_i,
    input  logic [PCT_W-1:0] pct_i,
    output logic             blocked_o,
    output tx_enables_t      en_o
);

    localparam logic [RUN_W-1:0] RUN_MAX   = '1;
    localparam logic [RUN_W-1:0] RUN_LIMIT = RUN_W'(BLOCK_RUNS);
    localparam logic [PCT_W-1:0] PCT_LIMIT = PCT_W'(BUSY_PCT);

    typedef struct packed {
        logic [RUN_W-1:0] trig;
        logic [RUN_W-1:0] quiet;
        logic             blocked;
        tx_enables_t      en;
    } hyst_state_t;

    hyst_state_t st_d, st_q;
    logic             busy_period;
    logic [RUN_W-1:0] trig_nxt;
    logic [RUN_W-1:0] quiet_nxt;

    always_comb begin
        busy_period = (pct_i > PCT_LIMIT);
        if (busy_period) begin
            trig_nxt  = (st_q.trig == RUN_MAX) ? st_q.trig : st_q.trig + 1'b1;
            quiet_nxt = '0;
        end else begin
            trig_nxt  = '0;
            quiet_nxt = (st_q.quiet == RUN_MAX) ? st_q.quiet : st_q.quiet + 1'b1;
        end

        st_d = st_q;
        if (clr_i) begin
            st_d.trig    = '0;
            st_d.quiet   = '0;
            st_d.blocked = 1'b0;
            st_d.en      = EN_ALL_ON;
        end else if (eval_vld_i) begin
            st_d.trig  = trig_nxt;
            st_d.quiet = quiet_nxt;
            if ((trig_nxt > RUN_LIMIT) && !st_q.blocked) begin
                st_d.blocked     = 1'b1;
                st_d.en.mac_tx   = 1'b0;
                st_d.en.auto_rsp = 1'b0;
                st_d.en.tx_ant   = 1'b0;
                st_d.en.rx_ant   = 1'b0;
            end else if ((quiet_nxt > RUN_LIMIT) && st_q.blocked) begin
                st_d.blocked = 1'b0;
                st_d.en      = EN_ALL_ON;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.trig    <= '0;
            st_q.quiet   <= '0;
            st_q.blocked <= 1'b0;
            st_q.en      <= EN_ALL_ON;
        end else begin
            st_q <= st_d;
        end
    end

    assign blocked_o = st_q.blocked;
    assign en_o      = st_q.en;

endmodule

// File: rtl/edg_thresh.sv
// Band-dependent energy threshold, duplicated into both halves of the word.
module edg_thresh #(
    parameter int unsigned TH_W  = 8,
    parameter int unsigned TH_HI = 8'h0E,
    parameter int unsigned TH_LO = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              band_hi_i,
    output logic [2*TH_W-1:0] thresh_o
);

    localparam logic [TH_W-1:0] HI_VAL = TH_W'(TH_HI);
    localparam logic [TH_W-1:0] LO_VAL = TH_W'(TH_LO);

    logic [2*TH_W-1:0] word_d, word_q;

    always_comb begin
        for (int unsigned i = 0; i < 2; i++) begin
            word_d[i*TH_W +: TH_W] = band_hi_i ? HI_VAL : LO_VAL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= {LO_VAL, LO_VAL};
        end else begin
            word_q <= word_d;
        end
    end

    assign thresh_o = word_q;

endmodule

// File: rtl/edg_txgate.sv
module edg_txgate
    import edg_pkg::*;
#(
    parameter int unsigned PERIOD     = 1000,
    parameter int unsigned RUN_W      = 8,
    parameter int unsigned BLOCK_RUNS = 2,
    parameter int unsigned BUSY_PCT   = 90,
    parameter int unsigned TH_W       = 8,
    parameter int unsigned TH_HI      = 8'h0E,
    parameter int unsigned TH_LO      = 8'h20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              energy_i,
    input  logic              regmode_i,
    input  logic              reinit_i,
    input  logic              band_hi_i,
    output logic              eval_vld_o,
    output logic [PCT_W-1:0]  busy_pct_o,
    output logic              tx_blocked_o,
    output logic              mac_tx_en_o,
    output logic              auto_rsp_en_o,
    output logic              tx_ant_en_o,
    output logic              rx_ant_en_o,
    output logic              rf_pin_en_o,
    output logic              trsw_en_o,
    output logic [2*TH_W-1:0] ed_thresh_o
);

    localparam int unsigned CNT_W = $clog2(PERIOD + 1);

    logic             clr;
    logic             eval_vld;
    logic [CNT_W-1:0] busy_tot;
    logic [PCT_W-1:0] pct;
    tx_enables_t      en;

    // leaving regulatory mode behaves like a re-initialisation
    assign clr = reinit_i | ~regmode_i;

    edg_acc #(.PERIOD(PERIOD), .CNT_W(CNT_W)) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .energy_i   (energy_i),
        .eval_vld_o (eval_vld),
        .busy_tot_o (busy_tot)
    );

    edg_pct #(.PERIOD(PERIOD), .CNT_W(CNT_W)) pct_i (
        .busy_tot_i (busy_tot),
        .pct_o      (pct)
    );

    edg_hyst #(.RUN_W(RUN_W), .BLOCK_RUNS(BLOCK_RUNS), .BUSY_PCT(BUSY_PCT)) hyst_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (clr),
        .eval_vld_i (eval_vld),
        .pct_i      (pct),
        .blocked_o  (tx_blocked_o),
        .en_o       (en)
    );

    edg_thresh #(.TH_W(TH_W), .TH_HI(TH_HI), .TH_LO(TH_LO)) thresh_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .band_hi_i (band_hi_i),
        .thresh_o  (ed_thresh_o)
    );

    assign eval_vld_o    = eval_vld;
    assign busy_pct_o    = pct;
    assign mac_tx_en_o   = en.mac_tx;
    assign auto_rsp_en_o = en.auto_rsp;
    assign tx_ant_en_o   = en.tx_ant;
    assign rx_ant_en_o   = en.rx_ant;
    assign rf_pin_en_o   = en.rf_pin;
    assign trsw_en_o     = en.trsw;

endmodule

// File: rtl/edg_txgate_chk.sv
module edg_txgate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reinit_i,
    input logic       regmode_i,
    input logic       eval_vld_o,
    input logic [6:0] busy_pct_o,
    input logic       tx_blocked_o
);

    AST_PCT_CLAMPED: assert property (@(posedge clk) disable iff (!rst_n)
        eval_vld_o |-> busy_pct_o <= 7'd100); // R1

    AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        eval_vld_o |=> !eval_vld_o); // R1

    AST_BLOCK_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_blocked_o) |-> $past(eval_vld_o) && ($past(busy_pct_o) > 7'd90)); // R3

    AST_GATE_MOVES_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tx_blocked_o) |-> $past(eval_vld_o) || $past(reinit_i) || !$past(regmode_i)); // R5

    AST_REINIT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        reinit_i |=> !tx_blocked_o); // R7

    AST_IDLE_NO_EVAL: assert property (@(posedge clk) disable iff (!rst_n)
        !regmode_i |=> !eval_vld_o && !tx_blocked_o); // R8

endmodule

bind edg_txgate edg_txgate_chk chk_i (.*);

// File: tb/edg_txgate_tb_top.sv
module edg_txgate_tb_top;

    localparam int unsigned PERIOD = 75;

    typedef struct {
        int    pct;
        bit    blk;
        bit    pre_blk;
        string req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        energy = 1'b0;
    logic        regmode = 1'b0;
    logic        reinit = 1'b0;
    logic        band_hi = 1'b0;
    logic        eval_vld;
    logic [6:0]  busy_pct;
    logic        tx_blocked;
    logic        mac_en, rsp_en, txa_en, rxa_en, rf_en, trsw_en;
    logic [15:0] thresh;

    int n_chk = 0;
    int n_bad = 0;
    int n_eval = 0;
    bit finished = 1'b0;

    exp_t sb_q[$];
    int   m_trig = 0;
    int   m_quiet = 0;
    bit   m_blk = 1'b0;

    always #10 clk = ~clk;

    edg_txgate #(.PERIOD(PERIOD)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .energy_i      (energy),
        .regmode_i     (regmode),
        .reinit_i      (reinit),
        .band_hi_i     (band_hi),
        .eval_vld_o    (eval_vld),
        .busy_pct_o    (busy_pct),
        .tx_blocked_o  (tx_blocked),
        .mac_tx_en_o   (mac_en),
        .auto_rsp_en_o (rsp_en),
        .tx_ant_en_o   (txa_en),
        .rx_ant_en_o   (rxa_en),
        .rf_pin_en_o   (rf_en),
        .trsw_en_o     (trsw_en),
        .ed_thresh_o   (thresh)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_enables(input bit blk, input string req);
        chk(mac_en == !blk, req, "mac_tx_en", mac_en, !blk);
        chk(rsp_en == !blk, req, "auto_rsp_en", rsp_en, !blk);
        chk(txa_en == !blk, req, "tx_ant_en", txa_en, !blk);
        chk(rxa_en == !blk, req, "rx_ant_en", rxa_en, !blk);
        chk(rf_en == 1'b1, req, "rf_pin_en", rf_en, 1);
        chk(trsw_en == 1'b1, req, "trsw_en", trsw_en, 1);
    endtask

    task automatic model_clear();
        m_trig = 0;
        m_quiet = 0;
        m_blk = 1'b0;
    endtask

    // Driver: one full period with n busy cycles; pushes the expected result.
    task automatic drive_period(input int n, input string req);
        exp_t it;
        int   pct;
        pct = (n * 100) / PERIOD;
        if (pct > 100) pct = 100;
        it.pre_blk = m_blk;
        if (pct > 90) begin
            m_trig++;
            m_quiet = 0;
        end else begin
            m_quiet++;
            m_trig = 0;
        end
        if (m_trig > 2 && !m_blk) m_blk = 1'b1;
        else if (m_quiet > 2 && m_blk) m_blk = 1'b0;
        it.pct = pct;
        it.blk = m_blk;
        it.req = req;
        sb_q.push_back(it);
        for (int i = 0; i < PERIOD; i++) begin
            energy = (i < n);
            @(negedge clk);
        end
        energy = 1'b0;
    endtask

    task automatic drain();
        repeat (4) @(negedge clk);
    endtask

    task automatic do_reinit();
        reinit = 1'b1;
        @(negedge clk);
        reinit = 1'b0;
        model_clear();
    endtask

    // Monitor: pops expected items on each evaluation strobe.
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            if (eval_vld === 1'b1) begin
                n_eval++;
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected eval_vld", 1, 0);
                end else begin
                    it = sb_q.pop_front();
                    chk(busy_pct == 7'(it.pct), "R1", "busy_pct", busy_pct, it.pct);
                    chk(tx_blocked == it.pre_blk, "R5", "blocked before update", tx_blocked, it.pre_blk);
                    @(negedge clk);
                    chk(eval_vld == 1'b0, "R1", "strobe width", eval_vld, 0);
                    chk(tx_blocked == it.blk, it.req, "tx_blocked", tx_blocked, it.blk);
                    chk_enables(it.blk, "R6");
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "WDOG", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int ev0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state
        chk(tx_blocked == 1'b0, "R10", "reset blocked", tx_blocked, 0);
        chk(eval_vld == 1'b0, "R10", "reset eval", eval_vld, 0);
        chk_enables(1'b0, "R10");
        chk(thresh == 16'h2020, "R10", "reset thresh", thresh, 16'h2020);

        // R9 threshold per band
        band_hi = 1'b1;
        @(negedge clk);
        chk(thresh == 16'h0E0E, "R9", "thresh high band", thresh, 16'h0E0E);
        band_hi = 1'b0;
        @(negedge clk);
        chk(thresh == 16'h2020, "R9", "thresh low band", thresh, 16'h2020);

        // R8 inactive: full energy, no evaluation
        ev0 = n_eval;
        for (int i = 0; i < 3 * PERIOD; i++) begin
            energy = 1'b1;
            @(negedge clk);
        end
        energy = 1'b0;
        chk(n_eval == ev0, "R8", "evals while inactive", n_eval - ev0, 0);
        chk(tx_blocked == 1'b0, "R8", "blocked while inactive", tx_blocked, 0);

        // R2 boundary: 68/75 -> 90 % quiet, 69/75 -> 92 % busy
        regmode = 1'b1;
        model_clear();
        drive_period(68, "R2");
        drive_period(68, "R2");
        drive_period(68, "R2");
        drive_period(69, "R2");
        drive_period(69, "R3");
        drive_period(69, "R3");   // third busy -> blocked
        // R4 quiet run
        drive_period(68, "R4");
        drive_period(0, "R4");
        drive_period(75, "R4");   // busy restarts quiet run
        drive_period(30, "R4");
        drive_period(10, "R4");
        drive_period(0, "R4");    // third quiet -> open
        // R3 interrupted busy run
        drive_period(75, "R3");
        drive_period(75, "R3");
        drive_period(50, "R3");
        drive_period(75, "R3");
        drive_period(75, "R3");
        drive_period(75, "R3");   // blocked
        drain();
        chk(tx_blocked == 1'b1, "R3", "blocked after run", tx_blocked, 1);
        chk(sb_q.size() == 0, "R1", "pending evals", sb_q.size(), 0);

        // R7 reinit while blocked
        do_reinit();
        chk(tx_blocked == 1'b0, "R7", "reinit unblocks", tx_blocked, 0);
        chk_enables(1'b0, "R7");
        drive_period(75, "R7");
        drive_period(75, "R7");   // only two since reinit -> still open
        drive_period(75, "R7");   // third -> blocked
        drain();

        // R8 dropping regulatory mode while blocked
        chk(tx_blocked == 1'b1, "R8", "blocked before drop", tx_blocked, 1);
        regmode = 1'b0;
        @(negedge clk);
        model_clear();
        chk(tx_blocked == 1'b0, "R8", "drop unblocks", tx_blocked, 0);
        chk_enables(1'b0, "R8");
        regmode = 1'b1;
        drive_period(75, "R8");
        drive_period(75, "R8");
        drain();
        chk(tx_blocked == 1'b0, "R8", "history cleared", tx_blocked, 0);
        chk(sb_q.size() == 0, "R1", "pending evals end", sb_q.size(), 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule